// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block returns a two-wire I2C bus to the idle state when an I2C master no longer knows where the bus stands, or when a target device is holding the data line low. It drives the clock line and the data line open-drain style: each output is a pull-low enable, and a zero leaves the line to the pull-up. It reads both lines back through a two-flop synchronizer and bases every decision on those synchronized copies.

A single-cycle `start_i` launches one run. If SCL reads low, nothing can be done from this side, so the block reports that at once and drives nothing. If SDA reads high, a plain STOP is produced and the run ends well. If SDA reads low, the block gives up to nine SCL pulses. It checks SDA at the close of each pulse's high phase and moves to the STOP once SDA is free. If SDA is still low after the ninth pulse, it reports that the devices need a hardware reset. Every phase of the generated waveform lasts `half_period_i` clock cycles. A value of 0 counts as 1, and values of 4 or more give the synchronized SDA time to settle before it is sampled.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset both pull-low enables are 0, `busy_o` is 0 and none of the three result flags is set.
- R2: If synchronized SCL is low when `start_i` is taken, `scl_stuck_o` pulses in the cycle after that edge, `busy_o` stays 0, and neither line is pulled low.
- R3: If SCL and SDA both read high at start, the run is four phases with no extra clocking: SCL low, SDA low, SCL released, SDA released. `done_ok_o` appears 4*H cycles after the start edge, with exactly one SCL rising edge during the run.
- R4: If SDA reads low at start, each recovery pulse holds SCL low for H cycles and then releases it for H cycles. SDA is sampled at the end of the high half. When it is found high after pulse K, the four-phase STOP follows and `done_ok_o` appears 2*H*K+4*H cycles after the start edge, with K+1 SCL rising edges in total.
- R5: At most 9 recovery pulses are given. Release after exactly the ninth still ends in success. If SDA is still low after the ninth, `sda_fail_o` appears 18*H cycles after the start edge and both lines are left released.
- R6: On a successful run the last bus event is a STOP (SDA rising while SCL is high), and no SCL or SDA edge follows it.
- R7: The block never pulls SDA low while SCL is released, so it never creates a START and never sends a START followed by a STOP.
- R8: `start_i` has no effect while `busy_o` is 1. The run's timing and its single result are unchanged.
- R9: Each run produces exactly one one-cycle pulse among `done_ok_o`, `scl_stuck_o` and `sda_fail_o`. `busy_o` is 1 from the cycle after the start edge until the result pulse, and 0 from then on.
- R10: The length of each phase is `half_period_i` cycles, and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the clear sequence |
| half_period_i | input | DIV_W | Phase length in clock cycles (0 treated as 1) |
| scl_i | input | 1 | SCL line level as read from the pad |
| sda_i | input | 1 | SDA line level as read from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | A run is in progress |
| done_ok_o | output | 1 | One-cycle pulse: bus returned to idle with a STOP |
| scl_stuck_o | output | 1 | One-cycle pulse: SCL read low at start, nothing driven |
| sda_fail_o | output | 1 | One-cycle pulse: SDA still low after the last pulse |

## Verification
Each result has a fixed delay from the clock edge that accepts `start_i`. The SCL-stuck flag is due in the cycle right after that edge. A STOP-only run ends after 4*H cycles, a recovery that frees SDA after K pulses ends after 2*H*K+4*H cycles, and a failed recovery ends after 18*H cycles. The bench counts clock edges from the accepting edge, reads outputs 1 ns after each edge, and compares the cycle of the first result pulse with these formulas. It keeps watching for another 2*H+4 cycles after the result, to catch a second pulse or a line that was not released. A bench model of a target counts SCL rising edges to decide when it frees SDA, and a bus monitor records SCL edges, START events and whether the last event was a STOP.

// File: rtl/i2c_clr_pkg.sv
package i2c_clr_pkg;

    // Sequencer states; TGL_* form one recovery pulse, STP_* the four STOP phases.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TGL_LO   = 3'd1,
        ST_TGL_HI   = 3'd2,
        ST_STP_LO   = 3'd3,
        ST_STP_SDA  = 3'd4,
        ST_STP_SCLH = 3'd5,
        ST_STP_REL  = 3'd6
    } clr_state_e;

    typedef struct packed {
        clr_state_e state;
        logic       scl_oe;
        logic       sda_oe;
        logic       done_ok;
        logic       scl_stuck;
        logic       sda_fail;
    } clr_regs_t;

    localparam clr_regs_t CLR_REGS_RESET = '{
        state:     ST_IDLE,
        scl_oe:    1'b0,
        sda_oe:    1'b0,
        done_ok:   1'b0,
        scl_stuck: 1'b0,
        sda_fail:  1'b0
    };

endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RESET_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clr_timer.sv
module clr_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             expire_o
);

    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W:0]   cnt_inc;

    // One phase lasts max(half_i,1) cycles: expire on the cycle whose
    // incremented count reaches the programmed length.
    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
        expire_o = run_i && (cnt_inc >= {1'b0, half_i});
        if (!run_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_inc[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10: inside a phase the count advances by exactly one per cycle
    p_phase_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !expire_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10: idle time leaves the count at zero for the next phase
    p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/clr_pulse_cnt.sv
module clr_pulse_cnt #(
    parameter int MAX_PULSES = 9,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        // The pulse now ending is the final one allowed.
        last_o = (cnt_q == CNT_W'(MAX_PULSES - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: the number of recovery pulses never exceeds the limit
    p_pulse_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(MAX_PULSES));

    // R4: every completed pulse is counted once
    p_pulse_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import i2c_clr_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int MAX_PULSES  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DIV_W-1:0] half_period_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_ok_o,
    output logic             scl_stuck_o,
    output logic             sda_fail_o
);

    localparam int PULSE_W = $clog2(MAX_PULSES + 1);
    localparam int LINES   = 2;

    clr_regs_t     regs_q, regs_d;
    logic [LINES-1:0] lines_s;
    logic          scl_s, sda_s;
    logic          phase_end;
    logic          last_pulse;
    logic          in_run;
    logic          pulse_done;

    // Line synchronizers: bit 1 SCL, bit 0 SDA; idle bus reads high.
    clr_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINES{1'b1}})
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    assign in_run = (regs_q.state != ST_IDLE);

    clr_timer #(
        .DIV_W (DIV_W)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (in_run),
        .half_i   (half_period_i),
        .expire_o (phase_end)
    );

    assign pulse_done = (regs_q.state == ST_TGL_HI) && phase_end;

    clr_pulse_cnt #(
        .MAX_PULSES (MAX_PULSES),
        .CNT_W      (PULSE_W)
    ) i_pulses (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (!in_run),
        .step_i  (pulse_done),
        .last_o  (last_pulse)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.done_ok   = 1'b0;
        regs_d.scl_stuck = 1'b0;
        regs_d.sda_fail  = 1'b0;

        unique case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!scl_s) begin
                        regs_d.scl_stuck = 1'b1;
                    end else if (!sda_s) begin
                        regs_d.state = ST_TGL_LO;
                    end else begin
                        regs_d.state = ST_STP_LO;
                    end
                end
            end
            ST_TGL_LO: begin
                if (phase_end) regs_d.state = ST_TGL_HI;
            end
            ST_TGL_HI: begin
                if (phase_end) begin
                    if (sda_s) begin
                        regs_d.state = ST_STP_LO;
                    end else if (last_pulse) begin
                        regs_d.state    = ST_IDLE;
                        regs_d.sda_fail = 1'b1;
                    end else begin
                        regs_d.state = ST_TGL_LO;
                    end
                end
            end
            ST_STP_LO: begin
                if (phase_end) regs_d.state = ST_STP_SDA;
            end
            ST_STP_SDA: begin
                if (phase_end) regs_d.state = ST_STP_SCLH;
            end
            ST_STP_SCLH: begin
                if (phase_end) regs_d.state = ST_STP_REL;
            end
            ST_STP_REL: begin
                if (phase_end) begin
                    regs_d.state   = ST_IDLE;
                    regs_d.done_ok = 1'b1;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase

        // Pull-low enables follow the state being entered, so they are registered.
        regs_d.scl_oe = (regs_d.state == ST_TGL_LO) ||
                        (regs_d.state == ST_STP_LO) ||
                        (regs_d.state == ST_STP_SDA);
        regs_d.sda_oe = (regs_d.state == ST_STP_SDA) ||
                        (regs_d.state == ST_STP_SCLH);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= CLR_REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign scl_oe_o    = regs_q.scl_oe;
    assign sda_oe_o    = regs_q.sda_oe;
    assign busy_o      = in_run;
    assign done_ok_o   = regs_q.done_ok;
    assign scl_stuck_o = regs_q.scl_stuck;
    assign sda_fail_o  = regs_q.sda_fail;

    // R1: outside a run the bus is left to the pull-ups
    p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    // R2: a stuck clock is reported without any drive or run
    p_stuck_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_stuck_o |-> (!busy_o && !$past(busy_o) && !scl_oe_o && !sda_oe_o));

    // R7: SDA is only pulled low while SCL is already held low
    p_no_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> (scl_oe_o && $past(scl_oe_o)));

    // R6: SDA is released only with SCL released, which forms a STOP
    p_stop_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o)));

    // R6: success is reported only after both lines have been released
    p_done_after_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_ok_o |-> ($past(!sda_oe_o) && $past(!scl_oe_o)));

    // R9: at most one result pulse at a time, and never two in a row
    p_one_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({done_ok_o, scl_stuck_o, sda_fail_o}));

    p_result_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_ok_o || sda_fail_o) |=> !(done_ok_o || sda_fail_o));

    // R9: a completing run ends busy in the cycle of its result
    p_result_ends_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_ok_o || sda_fail_o) |-> ($past(busy_o) && !busy_o));

    // R8: a start request during a run does not restart or end it
    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !phase_end) |=> busy_o);

endmodule

// File: tb/test_i2c_bus_clear.sv
module test_i2c_bus_clear;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] hp = 16'd5;
    logic        scl_oe, sda_oe, busy, done_ok, scl_stuck, sda_fail;
    logic        scl_force_low = 1'b0;
    int          hold = 0;          // target holds SDA for this many SCL rises; >=100 forever
    logic        scl_line, sda_line;

    int checks = 0;
    int failures = 0;

    // bus monitor state
    logic scl_prev = 1'b1;
    logic sda_prev = 1'b1;
    int   rises = 0;
    int   starts = 0;
    bit   last_stop = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign scl_line = !scl_oe && !scl_force_low;
    assign sda_line = !sda_oe && (hold == 0);

    i2c_bus_clear i_i2c_bus_clear (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .half_period_i (hp),
        .scl_i         (scl_line),
        .sda_i         (sda_line),
        .scl_oe_o      (scl_oe),
        .sda_oe_o      (sda_oe),
        .busy_o        (busy),
        .done_ok_o     (done_ok),
        .scl_stuck_o   (scl_stuck),
        .sda_fail_o    (sda_fail)
    );

    always @(posedge clk) begin
        if (scl_line != scl_prev) last_stop = 1'b0;
        if (scl_line && !scl_prev) begin
            rises++;
            if (hold > 0 && hold < 100) hold--;
        end
        if (scl_line && scl_prev && sda_prev && !sda_line) begin
            starts++;
            last_stop = 1'b0;
        end
        if (scl_line && scl_prev && !sda_prev && sda_line) last_stop = 1'b1;
        if (!sda_line && sda_prev) last_stop = 1'b0;
        scl_prev = scl_line;
        sda_prev = sda_line;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // kind: 0 none, 1 done_ok, 2 scl_stuck, 3 sda_fail
    task automatic run_case(input int h, input int inject,
                            output int n, output int kind, output int flags,
                            output int busy_first, output int post_bad);
        int lim;
        int hh;
        hh = (h < 1) ? 1 : h;
        hp = 16'(h);
        repeat (6) @(posedge clk);
        #1;
        rises = 0; starts = 0; last_stop = 1'b0;
        n = -1; kind = 0; flags = 0; post_bad = 0; busy_first = 0;
        lim = 40 * hh + 50;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        for (int c = 0; c < lim; c++) begin
            if (c > 0) begin
                @(posedge clk);
                #1;
            end
            start = (c == inject) && (c > 0);
            if (c == 0) busy_first = int'(busy);
            if (n >= 0 && c > n && (busy || scl_oe || sda_oe)) post_bad++;
            flags += int'(done_ok) + int'(scl_stuck) + int'(sda_fail);
            if (n < 0 && (done_ok || scl_stuck || sda_fail)) begin
                n = c;
                kind = done_ok ? 1 : (scl_stuck ? 2 : 3);
            end
            if (n >= 0 && c >= n + 2 * hh + 4) break;
        end
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk(!scl_oe && !sda_oe, "R1", "oe after reset", int'(scl_oe) + int'(sda_oe), 0);
        chk(!busy, "R1", "busy after reset", int'(busy), 0);
        chk(!done_ok && !scl_stuck && !sda_fail, "R1", "flags after reset",
            int'(done_ok) + int'(scl_stuck) + int'(sda_fail), 0);
    endtask

    task automatic t_scl_stuck;
        int n, kind, flags, bf, pb;
        scl_force_low = 1'b1;
        run_case(5, -1, n, kind, flags, bf, pb);
        chk(kind == 2, "R2", "result kind", kind, 2);
        chk(n == 0, "R2", "flag cycle", n, 0);
        chk(bf == 0 && pb == 0, "R2", "busy or drive", bf + pb, 0);
        chk(flags == 1, "R9", "result pulses", flags, 1);
        scl_force_low = 1'b0;
    endtask

    task automatic t_stop_only(input int h, input string req);
        int n, kind, flags, bf, pb, hh;
        hh = (h < 1) ? 1 : h;
        hold = 0;
        run_case(h, -1, n, kind, flags, bf, pb);
        chk(kind == 1, req, "result kind", kind, 1);
        chk(n == 4 * hh, req, "done cycle", n, 4 * hh);
        chk(rises == 1, "R3", "scl rises", rises, 1);
        chk(starts == 0, "R7", "start events", starts, 0);
        chk(last_stop, "R6", "last event stop", int'(last_stop), 1);
        chk(flags == 1 && bf == 1 && pb == 0, "R9", "single result/busy",
            flags * 10 + bf, 11);
    endtask

    task automatic t_recover(input int h, input int k, input int inject, input string req);
        int n, kind, flags, bf, pb;
        hold = k;
        run_case(h, inject, n, kind, flags, bf, pb);
        chk(kind == 1, req, "result kind", kind, 1);
        chk(n == 2 * h * k + 4 * h, req, "done cycle", n, 2 * h * k + 4 * h);
        chk(rises == k + 1, "R4", "scl rises", rises, k + 1);
        chk(starts == 0, "R7", "start events", starts, 0);
        chk(last_stop, "R6", "last event stop", int'(last_stop), 1);
        chk(flags == 1 && pb == 0, "R9", "single result", flags, 1);
    endtask

    task automatic t_fail(input int h);
        int n, kind, flags, bf, pb;
        hold = 1000;
        run_case(h, -1, n, kind, flags, bf, pb);
        chk(kind == 3, "R5", "result kind", kind, 3);
        chk(n == 18 * h, "R5", "fail cycle", n, 18 * h);
        chk(rises == 9, "R5", "scl rises", rises, 9);
        chk(starts == 0, "R7", "start events", starts, 0);
        chk(pb == 0 && !scl_oe && !sda_oe, "R5", "lines released", pb, 0);
        chk(flags == 1, "R9", "result pulses", flags, 1);
        hold = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        t_scl_stuck();
        t_stop_only(5, "R3");
        t_stop_only(0, "R10");
        t_recover(5, 3, -1, "R4");
        t_recover(8, 1, -1, "R10");
        t_recover(4, 9, -1, "R5");
        t_recover(5, 2, 3, "R8");
        t_fail(5);
        summary();
        $finish;
    end

endmodule